// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance and Vector Generator

This block sits on the processor side of an external interrupt interface. Three active-low pins carry a priority level from 0 to 7, where 0 means no request. The block passes the pins through a two-flop synchronizer and then requires two equal samples in a row before it treats a level as valid. It compares that level against a 3-bit interrupt mask. It acts on a request only at an instruction boundary, which the execution unit signals with `insn_done`.

When a request is taken, the block raises the mask to the level being serviced and produces a vector number and a vector table address. The vector number comes from one of two sources:
- With the active-low autovector input asserted, the vector is 24 plus the level.
- Otherwise the block opens an acknowledge handshake and captures the 8-bit vector that the device drives.

The table address is four times the vector number. A restore input reloads the mask, which models the return from a service routine.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `take_irq` and `ack_req` are 0, `vec_num` and `vec_addr` are 0, and `mask` is 7.
- R2: The request level is the bitwise inverse of `irq_lvl_n`. When the pins read 3'b111 (level 0), no request is ever taken.
- R3: A level from 1 to 6 is taken only if it is strictly greater than `mask`. A level equal to or below the mask leaves `take_irq`, `ack_req` and `mask` unchanged.
- R4: A request is accepted only in a cycle with `insn_done` high. Without that cycle, `take_irq` and `ack_req` stay 0.
- R5: In the cycle `take_irq` is high, `mask` equals the level that was serviced.
- R6: If `autovec_n` is 0 at acceptance, `take_irq` rises one cycle later with `vec_num` = 24 + level and `vec_addr` = 4 × `vec_num`. For example, level 2 gives 26 and 0x068.
- R7: If `autovec_n` is 1 at acceptance, `ack_req` rises one cycle later and holds until a cycle with `ack_valid` high. One cycle after that cycle, `take_irq` is high, `ack_req` is 0, `vec_num` equals the captured `ack_vector`, and `vec_addr` = 4 × that value. For example, 64 gives 0x100 and 255 gives 0x3FC.
- R8: Level 7 is taken even when `mask` is 7. It is taken only once per assertion, and becomes eligible again only after the valid level has dropped below 7.
- R9: A level must be seen on two consecutive synchronized samples before it is used. A pin pulse lasting one cycle is never taken.
- R10: A cycle with `restore_en` high loads `restore_mask` into `mask` on the next edge. In that same cycle, no request is accepted.
- R11: `take_irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl_n | input | 3 | Active-low request level pins |
| autovec_n | input | 1 | Active-low autovector select, sampled at acceptance |
| insn_done | input | 1 | Instruction boundary, acceptance allowed |
| ack_valid | input | 1 | Device vector valid during acknowledge |
| ack_vector | input | 8 | Device-supplied vector number |
| restore_en | input | 1 | Load mask from `restore_mask` |
| restore_mask | input | 3 | Saved mask value |
| take_irq | output | 1 | One-cycle strobe: interrupt taken |
| vec_num | output | 8 | Vector number of the taken interrupt |
| vec_addr | output | 10 | Vector table byte address |
| mask | output | 3 | Current interrupt mask |
| ack_req | output | 1 | Acknowledge cycle in progress |

## Verification
Random trials draw a mask, a level, an autovector choice and a device byte. These trials show whether the strict greater-than comparison and the level-7 exception separate taken from ignored requests. They also show whether the two vector sources produce distinct numbers and correctly scaled addresses. Directed cases cover the remaining corners:
- a one-cycle pin glitch while `insn_done` is held high, which checks the filter;
- a restore that coincides with a boundary, which checks the one-cycle block;
- level 7 held across two boundaries and then re-presented, which checks one-shot behaviour and re-arming;
- the vector bytes 64 and 255, which mark the ends of the device range.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int LVL_W  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] pin_n,
  output logic [LVL_W-1:0] level
);
  logic [STAGES-1:0][LVL_W-1:0] chain;
  logic [LVL_W-1:0]             prev;
  logic [LVL_W-1:0]             sampled;

  assign sampled = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= '0;
      level <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= ~pin_n;
      prev     <= sampled;
      if (sampled == prev) level <= sampled;
    end
  end

  // R9: the valid level only moves to a value seen on two samples in a row
  p_two_samples_r9: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> ($past(sampled) == $past(prev)));
endmodule

// File: rtl/irq_priority_gate.sv
module irq_priority_gate #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mask,
  input  logic             insn_done,
  input  logic             block,
  output logic             accept
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic top_armed;
  logic above_mask;
  logic top_pass;

  assign above_mask = level > mask;
  assign top_pass   = (level == LVL_MAX) && top_armed;
  assign accept     = insn_done && !block && (level != '0) && (above_mask || top_pass);

  always_ff @(posedge clk) begin
    if (rst)                              top_armed <= 1'b1;
    else if (accept && level == LVL_MAX)  top_armed <= 1'b0;
    else if (level != LVL_MAX)            top_armed <= 1'b1;
  end

  // R8: after the top level is taken, it is not taken again while still held
  p_top_once_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && level == LVL_MAX) |=> !(accept && level == LVL_MAX && mask == LVL_MAX));
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int AUTO_BASE = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [LVL_W-1:0]   level,
  input  logic               autovec_n,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vector,
  input  logic               restore_en,
  input  logic [LVL_W-1:0]   restore_mask,
  output logic               take_irq,
  output logic [VEC_W-1:0]   vec_num,
  output logic [VEC_W+1:0]   vec_addr,
  output logic [LVL_W-1:0]   mask,
  output logic               ack_req,
  output logic               busy
);
  localparam int ADDR_W = VEC_W + 2;

  seq_state_e       state;
  logic [LVL_W-1:0] lvl_hold;
  logic [VEC_W-1:0] auto_vec;

  assign auto_vec = VEC_W'(AUTO_BASE) + VEC_W'(level);
  assign busy     = (state == ST_ACK) || take_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      take_irq <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
      mask     <= '1;
      ack_req  <= 1'b0;
      lvl_hold <= '0;
    end else begin
      take_irq <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!autovec_n) begin
              take_irq <= 1'b1;
              vec_num  <= auto_vec;
              vec_addr <= ADDR_W'({auto_vec, 2'b00});
              mask     <= level;
            end else begin
              state    <= ST_ACK;
              ack_req  <= 1'b1;
              lvl_hold <= level;
            end
          end else if (restore_en) begin
            mask <= restore_mask;
          end
        end
        ST_ACK: begin
          if (ack_valid) begin
            take_irq <= 1'b1;
            vec_num  <= ack_vector;
            vec_addr <= ADDR_W'({ack_vector, 2'b00});
            mask     <= lvl_hold;
            ack_req  <= 1'b0;
            state    <= ST_IDLE;
          end else if (restore_en) begin
            mask <= restore_mask;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: the take strobe lasts one cycle
  p_take_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);

  // R7: the acknowledge request holds until the device answers
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !ack_valid) |=> ack_req);

  // R5: a serviced level is never zero, so the mask is raised to a real level
  p_mask_level_r5: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (mask != '0));

  // R10: a restore without a simultaneous take loads the saved value
  p_restore_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restore_en) && !take_irq) |-> (mask == $past(restore_mask)));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int LVL_W       = 3,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AUTO_BASE   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   irq_lvl_n,
  input  logic               autovec_n,
  input  logic               insn_done,
  input  logic               ack_valid,
  input  logic [VEC_W-1:0]   ack_vector,
  input  logic               restore_en,
  input  logic [LVL_W-1:0]   restore_mask,
  output logic               take_irq,
  output logic [VEC_W-1:0]   vec_num,
  output logic [VEC_W+1:0]   vec_addr,
  output logic [LVL_W-1:0]   mask,
  output logic               ack_req
);
  logic [LVL_W-1:0] level;
  logic             accept;
  logic             busy;

  irq_level_sync #(.LVL_W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (irq_lvl_n),
    .level (level)
  );

  irq_priority_gate #(.LVL_W(LVL_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .level     (level),
    .mask      (mask),
    .insn_done (insn_done),
    .block     (restore_en || busy),
    .accept    (accept)
  );

  irq_vector_seq #(.LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept),
    .level        (level),
    .autovec_n    (autovec_n),
    .ack_valid    (ack_valid),
    .ack_vector   (ack_vector),
    .restore_en   (restore_en),
    .restore_mask (restore_mask),
    .take_irq     (take_irq),
    .vec_num      (vec_num),
    .vec_addr     (vec_addr),
    .mask         (mask),
    .ack_req      (ack_req),
    .busy         (busy)
  );

  // R4: an autovectored take always follows an instruction boundary
  p_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (take_irq && !$past(ack_req)) |-> $past(insn_done));
endmodule

// File: tb/test_irq_vector_unit.sv
`timescale 1ns/1ps
module test_irq_vector_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] irq_lvl_n;
  logic       autovec_n;
  logic       insn_done;
  logic       ack_valid;
  logic [7:0] ack_vector;
  logic       restore_en;
  logic [2:0] restore_mask;
  logic       take_irq;
  logic [7:0] vec_num;
  logic [9:0] vec_addr;
  logic [2:0] mask;
  logic       ack_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_vector_unit i_irq_vector_unit (
    .clk(clk), .rst(rst), .irq_lvl_n(irq_lvl_n), .autovec_n(autovec_n),
    .insn_done(insn_done), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .restore_en(restore_en), .restore_mask(restore_mask), .take_irq(take_irq),
    .vec_num(vec_num), .vec_addr(vec_addr), .mask(mask), .ack_req(ack_req)
  );

  function automatic int exp_auto_vec(int lvl);
    return 24 + lvl;
  endfunction

  function automatic bit exp_taken(int m, int lvl);
    return (lvl != 0) && ((lvl > m) || (lvl == 7));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restore(int m);
    @(negedge clk);
    restore_en = 1'b1; restore_mask = 3'(m);
    @(negedge clk);
    restore_en = 1'b0;
    chk(mask == 3'(m), "R10 restore load", int'(mask), m);
  endtask

  task automatic settle(int lvl);
    int seen = 0;
    irq_lvl_n = ~3'(lvl);
    repeat (6) begin
      @(negedge clk);
      if (take_irq || ack_req) seen++;
    end
    chk(seen == 0, "R4 no take without boundary", seen, 0);
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  task automatic trial(int m, int lvl, bit use_auto, int dv);
    restore(m);
    autovec_n = !use_auto;
    settle(lvl);
    boundary();
    if (exp_taken(m, lvl)) begin
      if (use_auto) begin
        chk(take_irq == 1'b1, "R6 take", int'(take_irq), 1);
        chk(vec_num == 8'(exp_auto_vec(lvl)), "R6 vec", int'(vec_num), exp_auto_vec(lvl));
        chk(vec_addr == 10'(4 * exp_auto_vec(lvl)), "R6 addr", int'(vec_addr), 4 * exp_auto_vec(lvl));
        chk(mask == 3'(lvl), "R5 mask raise", int'(mask), lvl);
        @(negedge clk);
        chk(take_irq == 1'b0, "R11 pulse", int'(take_irq), 0);
      end else begin
        chk(ack_req == 1'b1 && take_irq == 1'b0, "R7 ack_req", int'(ack_req), 1);
        @(negedge clk);
        chk(ack_req == 1'b1 && take_irq == 1'b0, "R7 ack hold", int'(ack_req), 1);
        ack_valid = 1'b1; ack_vector = 8'(dv);
        @(negedge clk);
        ack_valid = 1'b0;
        chk(take_irq == 1'b1 && ack_req == 1'b0, "R7 take", int'(take_irq), 1);
        chk(vec_num == 8'(dv), "R7 vec", int'(vec_num), dv);
        chk(vec_addr == 10'(4 * dv), "R7 addr", int'(vec_addr), 4 * dv);
        chk(mask == 3'(lvl), "R5 mask raise", int'(mask), lvl);
        @(negedge clk);
        chk(take_irq == 1'b0, "R11 pulse", int'(take_irq), 0);
      end
    end else begin
      chk(take_irq == 1'b0 && ack_req == 1'b0, "R3 ignored", int'(take_irq), 0);
      chk(mask == 3'(m), "R3 mask kept", int'(mask), m);
    end
    settle(0);
  endtask

  initial begin
    int seed;
    seed = 32'h1f2e3d;
    void'($urandom(seed));
    rst = 1'b1; irq_lvl_n = 3'b111; autovec_n = 1'b1; insn_done = 1'b0;
    ack_valid = 1'b0; ack_vector = '0; restore_en = 1'b0; restore_mask = '0;
    repeat (3) @(negedge clk);
    chk(take_irq == 0 && ack_req == 0 && vec_num == 0 && vec_addr == 0 && mask == 3'd7,
        "R1 reset", int'(mask), 7);
    rst = 1'b0;
    @(negedge clk);
    chk(mask == 3'd7 && take_irq == 0, "R1 after reset", int'(mask), 7);

    // R6: level 2 autovector gives 26 at 0x068
    trial(0, 2, 1'b1, 0);
    // R7: device vectors at both ends of the user range
    trial(1, 4, 1'b0, 64);
    trial(3, 6, 1'b0, 255);
    // R2: pins all high mean no request
    trial(0, 0, 1'b1, 0);
    // R3: equal level ignored
    trial(5, 5, 1'b1, 0);

    // R9: a one-cycle glitch with the boundary held high is never taken
    restore(0);
    autovec_n = 1'b0;
    insn_done = 1'b1;
    @(negedge clk);
    irq_lvl_n = ~3'd3;
    @(negedge clk);
    irq_lvl_n = 3'b111;
    begin
      int seen = 0;
      repeat (8) begin
        @(negedge clk);
        if (take_irq) seen++;
      end
      chk(seen == 0, "R9 glitch filtered", seen, 0);
    end
    insn_done = 1'b0;

    // R10: a restore coinciding with a boundary blocks acceptance
    restore(6);
    settle(5);
    restore_en = 1'b1; restore_mask = 3'd0; insn_done = 1'b1;
    @(negedge clk);
    restore_en = 1'b0; insn_done = 1'b0;
    chk(take_irq == 1'b0 && mask == 3'd0, "R10 block", int'(take_irq), 0);
    boundary();
    chk(take_irq == 1'b1 && mask == 3'd5, "R10 take after restore", int'(mask), 5);
    settle(0);

    // R8: level 7 beats mask 7, once per assertion, re-armed after a drop
    restore(7);
    settle(7);
    boundary();
    chk(take_irq == 1'b1 && vec_num == 8'd31 && vec_addr == 10'h07C, "R8 top taken",
        int'(vec_addr), 'h7C);
    @(negedge clk);
    boundary();
    chk(take_irq == 1'b0, "R8 held top not retaken", int'(take_irq), 0);
    settle(0);
    settle(7);
    boundary();
    chk(take_irq == 1'b1, "R8 top re-armed", int'(take_irq), 1);
    settle(0);

    // Random trials
    for (int k = 0; k < 200; k++) begin
      int m, lvl, dv;
      bit au;
      m   = int'($urandom_range(0, 7));
      lvl = int'($urandom_range(0, 7));
      au  = 1'($urandom_range(0, 1));
      dv  = int'($urandom_range(64, 255));
      trial(m, lvl, au, dv);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule